// File: doc/BRIEF.md
# 24-bit Accumulator Processor Core

This block is a small multi-cycle processor for a 24-bit accumulator machine. It holds five architectural registers: the accumulator A, the index register X, the link register L, a 15-bit program counter and a status word that carries a three-way condition code. Each instruction is one 24-bit word. The core fetches it one byte at a time from a byte-wide synchronous memory, decodes it and forms a target address. It then reads or writes a memory word, or reaches out to a byte-wide device port.

Words are three bytes, with the most significant byte at the lowest address. The memory port returns read data one cycle after a read strobe. The device side has two streams, each a valid/ready pair. Input bytes reach the core when it raises its ready and the device holds valid. Output bytes leave when the core raises valid and the device answers with ready. Either side may stall the other for any number of cycles, and the core holds its offered byte and device number steady until the transfer completes.

An opcode the core does not implement stops it. This includes divide. The core then raises `halt` and stays idle until reset.

Top module: `acc24_core`

## Requirements
- R1: While reset is held, `halt`, `mem_rd_en` and `mem_wr_en` are low. The first memory read after reset is at address 0. All registers start at zero.
- R2: An instruction word is fetched as three byte reads at PC, PC+1 and PC+2, in that order. The first byte is the opcode (bits 23:16), then the index flag (bit 15), then the 15-bit address field (bits 14:0). Memory words are read and written big-endian. A read and a write never occur in the same cycle.
- R3: The target address is the address field when the index flag is 0, and the address field plus the low 15 bits of X, modulo 2^15, when it is 1.
- R4: Opcode 00 loads A, 04 loads X and 08 loads L from the word at the target address. Opcodes 0C, 10 and 14 store A, X and L there. Opcode E8 stores the status word, which is zero except for the condition code in bits 7:6: 00 less, 01 equal, 10 greater.
- R5: ADD (18), SUB (1C) and MUL (20, the low 24 bits of the product) combine A with the memory word and place the result in A, wrapping modulo 2^24. AND (40) and OR (44) do the same bitwise. None of these five changes the condition code.
- R6: COMP (28) sets the condition code from a two's-complement comparison of A with the memory word. JLT (38), JEQ (30) and JGT (34) jump to the target only when the code is less, equal or greater respectively. J (3C) always jumps.
- R7: TIX (2C) adds one to X, then sets the condition code from a signed comparison of the new X with the memory word.
- R8: JSUB (48) puts the address of the next instruction, zero-extended, into L and jumps to the target. RSUB (4C) jumps to the address held in the low 15 bits of L.
- R9: LDCH (50) replaces bits 7:0 of A with the byte at the target address and keeps bits 23:8.
- R10: For device opcodes, the byte at the target address gives the device number driven on `dev_id`. TD (E0) sets the code to less when `dev_ready` is high and to equal when it is low.
- R11: RD (D8) raises `dev_rx_ready` until `dev_rx_valid` is seen, then puts `dev_rx_data` into bits 7:0 of A. WD (DC) raises `dev_tx_valid` with bits 7:0 of A and holds the byte and `dev_id` stable until `dev_tx_ready` is seen.
- R12: DIV (24) and any opcode not listed here raise `halt`. Once raised, it stays high until reset and no memory access or device transfer occurs.
- R13: F0 and F4 change no register and continue with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 15 | Byte address |
| mem_rd_en | output | 1 | Read strobe; data returns on the next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte written |
| mem_rdata | input | 8 | Byte read, one cycle after the strobe |
| dev_id | output | 8 | Device number for the current device operation |
| dev_ready | input | 1 | Selected device is ready (sampled by TD) |
| dev_rx_valid | input | 1 | Input byte valid |
| dev_rx_data | input | 8 | Input byte |
| dev_rx_ready | output | 1 | Core accepts an input byte |
| dev_tx_valid | output | 1 | Output byte valid |
| dev_tx_data | output | 8 | Output byte |
| dev_tx_ready | input | 1 | Device accepts the output byte |
| halt | output | 1 | Core stopped on an unsupported opcode |

## Verification
The hardest states to reach from the ports are the ones that depend on earlier instructions. These are an indexed access after a count loop has moved X, a return address taken inside a subroutine, and a device transfer stalled by the far side. The stimulus reaches them with short programs placed in the bench memory. A TIX loop leaves a known X, which then drives indexed loads and byte loads. A subroutine stores L before returning. Device models hold valid or ready back for several cycles. Arithmetic and comparisons are swept over every pair from a set of boundary values, and after each program the bench reads the stored results back from its memory.

// File: rtl/acc24_pkg.sv
package acc24_pkg;
  localparam logic [7:0] OP_LDA  = 8'h00, OP_LDX  = 8'h04, OP_LDL  = 8'h08;
  localparam logic [7:0] OP_STA  = 8'h0C, OP_STX  = 8'h10, OP_STL  = 8'h14;
  localparam logic [7:0] OP_ADD  = 8'h18, OP_SUB  = 8'h1C, OP_MUL  = 8'h20;
  localparam logic [7:0] OP_COMP = 8'h28, OP_TIX  = 8'h2C, OP_JEQ  = 8'h30;
  localparam logic [7:0] OP_JGT  = 8'h34, OP_JLT  = 8'h38, OP_J    = 8'h3C;
  localparam logic [7:0] OP_AND  = 8'h40, OP_OR   = 8'h44, OP_JSUB = 8'h48;
  localparam logic [7:0] OP_RSUB = 8'h4C, OP_LDCH = 8'h50, OP_STSW = 8'hE8;
  localparam logic [7:0] OP_RD   = 8'hD8, OP_WD   = 8'hDC, OP_TD   = 8'hE0;
  localparam logic [7:0] OP_SIO  = 8'hF0, OP_HIO  = 8'hF4;

  typedef enum logic [1:0] {CC_LT = 2'b00, CC_EQ = 2'b01, CC_GT = 2'b10} cc_t;

  typedef enum logic [2:0] {
    K_WORD, K_BYTE, K_DEV, K_STORE, K_JUMP, K_NOP, K_BAD
  } kind_t;

  typedef enum logic [2:0] {
    S_IFGO, S_IF, S_DEC, S_RD, S_EXEC, S_WR, S_DEV, S_HALT
  } st_t;
endpackage

// File: rtl/acc24_agen.sv
module acc24_agen #(
  parameter int AW = 15
) (
  input  logic [AW-1:0] afield,
  input  logic          idx,
  input  logic [AW-1:0] xlow,
  output logic [AW-1:0] ta
);
  // Indexed addressing wraps inside the address space
  assign ta = afield + (idx ? xlow : '0);
endmodule

// File: rtl/acc24_alu.sv
module acc24_alu
  import acc24_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [7:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] xreg,
  input  logic [W-1:0] mword,
  output logic [W-1:0] res,
  output logic [W-1:0] xinc,
  output cc_t          cc
);
  logic [W-1:0] lhs;

  assign xinc = xreg + W'(1);
  assign lhs  = (op == OP_TIX) ? xinc : acc;

  always_comb begin
    case (op)
      OP_ADD:  res = acc + mword;
      OP_SUB:  res = acc - mword;
      OP_MUL:  res = acc * mword;
      OP_AND:  res = acc & mword;
      OP_OR:   res = acc | mword;
      default: res = mword;
    endcase
    if ($signed(lhs) < $signed(mword)) cc = CC_LT;
    else if (lhs == mword)             cc = CC_EQ;
    else                               cc = CC_GT;
  end
endmodule

// File: rtl/acc24_memseq.sv
module acc24_memseq #(
  parameter int AW = 15,
  parameter int W  = 24,
  parameter int BW = 8,
  localparam int NB = W / BW,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_rd,
  input  logic          start_wr,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] nbytes,
  input  logic [W-1:0]  wword,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [BW-1:0] mem_wdata,
  input  logic [BW-1:0] mem_rdata,
  output logic          done,
  output logic [W-1:0]  word
);
  logic          busy_q, wr_q, pend_q, issue;
  logic [CW-1:0] cnt_q, rcv_q, nb_q;
  logic [AW-1:0] base_q;
  logic [W-1:0]  sh_q;

  assign issue     = busy_q && (cnt_q != nb_q);
  assign mem_rd_en = issue && !wr_q;
  assign mem_wr_en = issue && wr_q;
  assign mem_addr  = base_q + AW'(cnt_q);
  assign mem_wdata = sh_q[W-1 -: BW];
  assign done      = busy_q && (wr_q ? (cnt_q == nb_q) : (rcv_q == nb_q));
  assign word      = sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wr_q <= 1'b0; pend_q <= 1'b0;
      cnt_q <= '0; rcv_q <= '0; nb_q <= '0; base_q <= '0; sh_q <= '0;
    end else begin
      pend_q <= mem_rd_en;
      if (!busy_q && (start_rd || start_wr)) begin
        busy_q <= 1'b1;
        wr_q   <= start_wr;
        base_q <= base;
        nb_q   <= nbytes;
        cnt_q  <= '0;
        rcv_q  <= '0;
        sh_q   <= start_wr ? wword : '0;
      end else if (busy_q) begin
        if (issue)     cnt_q <= cnt_q + CW'(1);
        if (mem_wr_en) sh_q  <= sh_q << BW;
        if (pend_q) begin
          sh_q  <= {sh_q[W-BW-1:0], mem_rdata};
          rcv_q <= rcv_q + CW'(1);
        end
        if (done) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acc24_core.sv
module acc24_core
  import acc24_pkg::*;
#(
  parameter int AW = 15,
  parameter int W  = 24,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [BW-1:0] mem_wdata,
  input  logic [BW-1:0] mem_rdata,
  output logic [BW-1:0] dev_id,
  input  logic          dev_ready,
  input  logic          dev_rx_valid,
  input  logic [BW-1:0] dev_rx_data,
  output logic          dev_rx_ready,
  output logic          dev_tx_valid,
  output logic [BW-1:0] dev_tx_data,
  input  logic          dev_tx_ready,
  output logic          halt
);
  localparam int NB = W / BW;
  localparam int CW = $clog2(NB + 1);

  st_t           st_q;
  cc_t           cc_q, alu_cc;
  kind_t         kind;
  logic [W-1:0]  a_q, x_q, l_q, ir_q, opnd_q, sw, alu_res, xinc, store_val, seq_word;
  logic [AW-1:0] pc_q, pc_next, ta, seq_base;
  logic [7:0]    opc;
  logic          seq_start_rd, seq_start_wr, seq_done, taken;
  logic [CW-1:0] seq_nb;

  assign opc     = ir_q[W-1 -: 8];
  assign pc_next = pc_q + AW'(NB);
  assign sw      = {{(W-8){1'b0}}, cc_q, 6'b0};

  acc24_agen #(.AW(AW)) u_agen (
    .afield(ir_q[AW-1:0]), .idx(ir_q[AW]), .xlow(x_q[AW-1:0]), .ta(ta)
  );

  acc24_alu #(.W(W)) u_alu (
    .op(opc), .acc(a_q), .xreg(x_q), .mword(opnd_q),
    .res(alu_res), .xinc(xinc), .cc(alu_cc)
  );

  always_comb begin
    case (opc)
      OP_LDA, OP_LDX, OP_LDL, OP_ADD, OP_SUB, OP_MUL,
      OP_AND, OP_OR, OP_COMP, OP_TIX:           kind = K_WORD;
      OP_LDCH:                                  kind = K_BYTE;
      OP_TD, OP_RD, OP_WD:                      kind = K_DEV;
      OP_STA, OP_STX, OP_STL, OP_STSW:          kind = K_STORE;
      OP_J, OP_JEQ, OP_JGT, OP_JLT,
      OP_JSUB, OP_RSUB:                         kind = K_JUMP;
      OP_SIO, OP_HIO:                           kind = K_NOP;
      default:                                  kind = K_BAD;
    endcase
    case (opc)
      OP_STX:  store_val = x_q;
      OP_STL:  store_val = l_q;
      OP_STSW: store_val = sw;
      default: store_val = a_q;
    endcase
    case (opc)
      OP_JLT:  taken = (cc_q == CC_LT);
      OP_JEQ:  taken = (cc_q == CC_EQ);
      OP_JGT:  taken = (cc_q == CC_GT);
      default: taken = 1'b1;
    endcase
  end

  assign seq_start_rd = (st_q == S_IFGO) ||
                        (st_q == S_DEC && (kind == K_WORD || kind == K_BYTE || kind == K_DEV));
  assign seq_start_wr = (st_q == S_DEC) && (kind == K_STORE);
  assign seq_base     = (st_q == S_IFGO) ? pc_q : ta;
  assign seq_nb       = (st_q == S_IFGO || kind == K_WORD || kind == K_STORE) ? CW'(NB) : CW'(1);

  acc24_memseq #(.AW(AW), .W(W), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_rd(seq_start_rd), .start_wr(seq_start_wr),
    .base(seq_base), .nbytes(seq_nb), .wword(store_val),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(seq_done), .word(seq_word)
  );

  assign dev_id       = opnd_q[BW-1:0];
  assign dev_rx_ready = (st_q == S_DEV) && (opc == OP_RD);
  assign dev_tx_valid = (st_q == S_DEV) && (opc == OP_WD);
  assign dev_tx_data  = a_q[BW-1:0];
  assign halt         = (st_q == S_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IFGO; cc_q <= CC_LT; pc_q <= '0;
      a_q <= '0; x_q <= '0; l_q <= '0; ir_q <= '0; opnd_q <= '0;
    end else begin
      case (st_q)
        S_IFGO: st_q <= S_IF;
        S_IF: if (seq_done) begin
          ir_q <= seq_word;
          st_q <= S_DEC;
        end
        S_DEC: begin
          pc_q <= pc_next;
          case (kind)
            K_WORD, K_BYTE, K_DEV: st_q <= S_RD;
            K_STORE:               st_q <= S_WR;
            K_JUMP: begin
              if (opc == OP_JSUB) l_q <= W'(pc_next);
              if (opc == OP_RSUB) pc_q <= l_q[AW-1:0];
              else if (taken)     pc_q <= ta;
              st_q <= S_IFGO;
            end
            K_NOP:   st_q <= S_IFGO;
            default: st_q <= S_HALT;
          endcase
        end
        S_RD: if (seq_done) begin
          opnd_q <= seq_word;
          st_q   <= (kind == K_DEV) ? S_DEV : S_EXEC;
        end
        S_EXEC: begin
          case (opc)
            OP_LDX:  x_q <= opnd_q;
            OP_LDL:  l_q <= opnd_q;
            OP_COMP: cc_q <= alu_cc;
            OP_TIX:  begin x_q <= xinc; cc_q <= alu_cc; end
            OP_LDCH: a_q[BW-1:0] <= opnd_q[BW-1:0];
            default: a_q <= alu_res;
          endcase
          st_q <= S_IFGO;
        end
        S_WR: if (seq_done) st_q <= S_IFGO;
        S_DEV: begin
          if (opc == OP_TD) begin
            cc_q <= dev_ready ? CC_LT : CC_EQ;
            st_q <= S_IFGO;
          end else if (opc == OP_RD) begin
            if (dev_rx_valid) begin
              a_q[BW-1:0] <= dev_rx_data;
              st_q <= S_IFGO;
            end
          end else if (dev_tx_ready) begin
            st_q <= S_IFGO;
          end
        end
        default: st_q <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc24_core_chk.sv
module acc24_core_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [BW-1:0] dev_id,
  input logic          dev_rx_ready,
  input logic          dev_tx_valid,
  input logic [BW-1:0] dev_tx_data,
  input logic          dev_tx_ready,
  input logic          halt
);
  // R2: one memory direction per cycle
  p_rw_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  // R12: halt is held until reset
  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  // R12: a halted core is silent on both ports
  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !mem_rd_en && !mem_wr_en && !dev_tx_valid && !dev_rx_ready);

  // R11: an offered output byte waits, unchanged, for the device
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid && !dev_tx_ready |=> dev_tx_valid && $stable(dev_tx_data) && $stable(dev_id));

  // R11: one device stream active at a time
  p_dev_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_tx_valid && dev_rx_ready));
endmodule

bind acc24_core acc24_core_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .dev_id(dev_id), .dev_rx_ready(dev_rx_ready), .dev_tx_valid(dev_tx_valid),
  .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready), .halt(halt)
);

// File: tb/tb_acc24_core.sv
`timescale 1ns/1ps
module tb_acc24_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  dev_id, dev_rx_data, dev_tx_data;
  logic        dev_ready, dev_rx_valid, dev_rx_ready, dev_tx_valid, dev_tx_ready, halt;

  logic [7:0]  mem [0:4095];
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  acc24_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_id(dev_id), .dev_ready(dev_ready), .dev_rx_valid(dev_rx_valid),
    .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
    .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
    .dev_tx_ready(dev_tx_ready), .halt(halt)
  );

  // Byte memory with one-cycle read latency and a loader port
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr_en) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr[11:0]];
  end

  // Device models: number 5 is ready, others are not; both streams stall
  int rx_cnt, tx_cnt, tx_n, quiet_bad;
  logic [7:0] tx_byte, tx_id;
  logic [14:0] first_addr;
  logic seen_rd;
  assign dev_ready    = (dev_id == 8'h05);
  assign dev_rx_valid = (rx_cnt >= 3);
  assign dev_rx_data  = 8'h5A;
  assign dev_tx_ready = (tx_cnt >= 2);

  always @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt <= 0; tx_cnt <= 0; tx_n <= 0; quiet_bad <= 0; seen_rd <= 1'b0;
      tx_byte <= '0; tx_id <= '0; first_addr <= '1;
    end else begin
      if (dev_rx_ready && dev_rx_valid) rx_cnt <= 0;
      else if (dev_rx_ready) rx_cnt <= rx_cnt + 1;
      if (dev_tx_valid && dev_tx_ready) begin
        tx_cnt <= 0; tx_n <= tx_n + 1; tx_byte <= dev_tx_data; tx_id <= dev_id;
      end else if (dev_tx_valid) tx_cnt <= tx_cnt + 1;
      if (mem_rd_en && !seen_rd) begin seen_rd <= 1'b1; first_addr <= mem_addr; end
      if (halt && (mem_rd_en || mem_wr_en)) quiet_bad <= quiet_bad + 1;
    end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_b(input int a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a[11:0]; ld_data = d;
  endtask

  task automatic put_w(input int a, input logic [23:0] v);
    put_b(a, v[23:16]); put_b(a + 1, v[15:8]); put_b(a + 2, v[7:0]);
  endtask

  // Instruction word: opcode, index flag, 15-bit address
  task automatic put_i(input int a, input logic [7:0] op, input int t, input bit x = 1'b0);
    put_w(a, {op, x, t[14:0]});
  endtask

  function automatic logic [23:0] rd_w(input int a);
    return {mem[a], mem[a + 1], mem[a + 2]};
  endfunction

  task automatic begin_load();
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 'h900; a < 'h924; a++) put_b(a, 8'h00);
  endtask

  task automatic run(input string req);
    bit done;
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b0;
    for (int c = 0; c < 4000 && !done; c++) begin
      @(negedge clk);
      if (halt) done = 1'b1;
    end
    chk({req, " halt reached"}, {23'd0, done}, 24'd1);
  endtask

  function automatic logic [23:0] val(input int k);
    case (k)
      0: return 24'h000000;  1: return 24'h000001;
      2: return 24'h000002;  3: return 24'hFFFFFF;
      4: return 24'h7FFFFF;  5: return 24'h800000;
      6: return 24'h000123;  default: return 24'hFFF000;
    endcase
  endfunction

  function automatic int sx(input logic [23:0] v);
    return int'({{8{v[23]}}, v});
  endfunction

  localparam int D = 'h800;

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // Program 1: arithmetic, logic, compare and branch sweep
    put_i(0, 8'h00, D);      put_i(3, 8'h28, D + 3);
    put_i(6, 8'h00, D);      put_i(9, 8'h40, D + 3);   put_i(12, 8'h0C, 'h900);
    put_i(15, 8'h00, D);     put_i(18, 8'h44, D + 3);  put_i(21, 8'h0C, 'h903);
    put_i(24, 8'hE8, 'h906);
    put_i(27, 8'h00, D);     put_i(30, 8'h18, D + 3);  put_i(33, 8'h0C, 'h909);
    put_i(36, 8'h00, D);     put_i(39, 8'h1C, D + 3);  put_i(42, 8'h0C, 'h90C);
    put_i(45, 8'h00, D);     put_i(48, 8'h20, D + 3);  put_i(51, 8'h0C, 'h90F);
    put_i(54, 8'h38, 72);    put_i(57, 8'h30, 81);     put_i(60, 8'h34, 90);
    put_i(63, 8'h00, D + 15); put_i(66, 8'h0C, 'h912); put_i(69, 8'hFF, 0);
    put_i(72, 8'h00, D + 6); put_i(75, 8'h0C, 'h912);  put_i(78, 8'hFF, 0);
    put_i(81, 8'h00, D + 9); put_i(84, 8'h0C, 'h912);  put_i(87, 8'hFF, 0);
    put_i(90, 8'h00, D + 12); put_i(93, 8'h3C, 99);    put_i(96, 8'hFF, 0);
    put_i(99, 8'h0C, 'h912); put_i(102, 8'hFF, 0);
    put_w(D + 6, 24'd1); put_w(D + 9, 24'd2); put_w(D + 12, 24'd3); put_w(D + 15, 24'd0);

    // R1: outputs quiet during reset
    @(negedge clk);
    chk("R1 reset halt", {23'd0, halt}, 24'd0);
    chk("R1 reset strobes", {22'd0, mem_rd_en, mem_wr_en}, 24'd0);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [23:0] a, b, esw, ebr, em;
        a = val(i); b = val(j);
        begin_load();
        put_w(D, a); put_w(D + 3, b);
        run("R2");
        em = a * b;
        if (sx(a) < sx(b))      begin esw = 24'h000000; ebr = 24'd1; end
        else if (a == b)        begin esw = 24'h000040; ebr = 24'd2; end
        else                    begin esw = 24'h000080; ebr = 24'd3; end
        chk("R5 AND", rd_w('h900), a & b);
        chk("R5 OR", rd_w('h903), a | b);
        chk("R4 R5 R6 status after COMP then AND/OR", rd_w('h906), esw);
        chk("R5 ADD", rd_w('h909), a + b);
        chk("R5 SUB", rd_w('h90C), a - b);
        chk("R5 MUL", rd_w('h90F), em);
        chk("R6 branch path", rd_w('h912), ebr);
        if (i == 0 && j == 0) chk("R1 first fetch address", {9'd0, first_addr}, 24'd0);
      end
    end

    // Program 2: index loop, indexing, byte load, subroutine, devices, divide
    begin_load();
    put_i(0, 8'h04, D);       put_i(3, 8'h00, D);       put_i(6, 8'h18, D + 3);
    put_i(9, 8'h2C, D + 6);   put_i(12, 8'h38, 6);      put_i(15, 8'h0C, 'h900);
    put_i(18, 8'h10, 'h903);  put_i(21, 8'hE8, 'h906);  put_i(24, 8'h00, D + 9, 1'b1);
    put_i(27, 8'h0C, 'h909);  put_i(30, 8'h00, D + 20); put_i(33, 8'h50, D + 24, 1'b1);
    put_i(36, 8'h0C, 'h90C);  put_i(39, 8'h48, 60);     put_i(42, 8'h08, D + 32);
    put_i(45, 8'h14, 'h912);  put_i(48, 8'hE0, D + 40); put_i(51, 8'hE8, 'h915);
    put_i(54, 8'h3C, 72);     put_i(57, 8'hFF, 0);
    put_i(60, 8'h14, 'h90F);  put_i(63, 8'h4C, 0);      put_i(66, 8'hFF, 0);
    put_i(72, 8'hE0, D + 41); put_i(75, 8'hE8, 'h918);  put_i(78, 8'hF0, 0);
    put_i(81, 8'hD8, D + 40); put_i(84, 8'h0C, 'h91B);  put_i(87, 8'hDC, D + 40);
    put_i(90, 8'h24, D + 3);  put_i(93, 8'h0C, 'h91E);
    put_w(D, 24'd0); put_w(D + 3, 24'd1); put_w(D + 6, 24'd5);
    put_w(D + 14, 24'h654321); put_w(D + 20, 24'h123456); put_b(D + 29, 8'hAB);
    put_w(D + 32, 24'h7ABCDE); put_b(D + 40, 8'h05); put_b(D + 41, 8'h07);
    run("R12 DIV");
    chk("R7 loop sum", rd_w('h900), 24'd5);
    chk("R7 R4 X after TIX", rd_w('h903), 24'd5);
    chk("R7 status equal", rd_w('h906), 24'h000040);
    chk("R3 indexed load", rd_w('h909), 24'h654321);
    chk("R9 byte load", rd_w('h90C), 24'h1234AB);
    chk("R8 return address", rd_w('h90F), 24'd42);
    chk("R8 R4 L load/store after return", rd_w('h912), 24'h7ABCDE);
    chk("R10 TD ready", rd_w('h915), 24'h000000);
    chk("R10 TD not ready", rd_w('h918), 24'h000040);
    chk("R11 R13 RD byte", rd_w('h91B), 24'h12345A);
    chk("R11 WD count", tx_n, 24'd1);
    chk("R11 WD byte", {16'd0, tx_byte}, 24'h00005A);
    chk("R10 WD device", {16'd0, tx_id}, 24'h000005);
    chk("R12 no store after DIV", rd_w('h91E), 24'd0);
    repeat (20) @(negedge clk);
    chk("R12 halt held", {23'd0, halt}, 24'd1);
    chk("R12 silent after halt", quiet_bad, 24'd0);

    // Program 3: channel no-op then an undefined opcode
    begin_load();
    put_i(0, 8'hF4, 0); put_i(3, 8'h00, D + 3); put_i(6, 8'h0C, 'h900);
    put_i(9, 8'h05, 0); put_i(12, 8'h0C, 'h903);
    run("R12 undefined");
    chk("R13 continues after F4", rd_w('h900), 24'd1);
    chk("R12 stops at undefined", rd_w('h903), 24'd0);
    repeat (20) @(negedge clk);
    chk("R12 silent after undefined", quiet_bad, 24'd0);
    chk("R1 fetch starts at 0", {9'd0, first_addr}, 24'd0);

    report();
  end
endmodule